// File: doc/BRIEF.md
# Memory Bank Select and Protection

This block sits between the bus interface and the external memory timing engines. Every bus access presents an address, a 3-bit address type code and a read/write direction. The block compares the access against eight programmable bank descriptors. It then reports which bank's chip select to drive, which timing engine serves the access, whether parity checking applies, and whether the access breaks the bank's write protection or hits no bank at all.

Each bank has two configuration words, a base word and an option word, plus one global word shared by all banks. All three are written through a single write port. The base word holds:

- the bank's base address, compared on address bits 31..15;
- the type code;
- the parity enable bit;
- the write-protect bit;
- the machine select field;
- the valid bit.

The option word holds the address compare mask and the type compare mask. The global word holds the parity polarity. The decode is registered. Its result appears for exactly one clock, one cycle after the request strobe.

Out of reset, bank 0 is valid, matches every address and type, and routes to the general-purpose machine. A boot device therefore answers without any programming.

Top module: `bank_select_unit`

## Requirements
- R1: After reset, all outputs are zero. Bank 0 is valid, read/write, parity off, machine select 0, with both masks zero, so it matches any access. Banks 1 to 7 are invalid.
- R2: A bank matches only when its valid bit (base word bit 0) is set and, on address bits 31..15, (address AND mask) equals (base AND mask). Base sits in base word bits 31..15 and mask in option word bits 31..15. A mask bit of 1 means the bit is compared.
- R3: A matching bank also requires the access type to equal the type code (base word bits 14..12) on every bit set in the type mask (option word bits 14..12).
- R4: When several banks match, only the lowest-numbered one drives its chip select (chipSel bit n for bank n). The chip-select vector is never more than one-hot.
- R5: A write whose winning bank has write-protect set (base word bit 10) drives no chip select and raises violation. A read of the same bank selects it normally.
- R6: When no bank matches, no chip select is driven and noMatch is high for one cycle.
- R7: machSel reports the winning bank's machine select field (base word bits 9..8): 0 general-purpose, 1 user machine A, 2 user machine B. It is 0 when no chip select is driven.
- R8: parityEn reports the winning bank's parity enable bit (base word bit 11) when its chip select is driven. parityOdd reflects bit 0 of the global word (1 = odd).
- R9: The decode outcome is presented on the outputs in the cycle after reqValid is sampled high, and for one cycle only. decodeValid marks that cycle. In every other cycle chipSel, violation, noMatch and parityEn are zero.
- R10: A configuration write selects the word with cfgSel (0 base, 1 option, 2 global; 3 is ignored) and the bank with cfgBank. It takes effect for requests sampled after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgBank | input | 3 | Bank addressed by the write |
| cfgSel | input | 2 | Word select: 0 base, 1 option, 2 global |
| cfgData | input | 32 | Configuration write data |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 32 | Access address |
| reqType | input | 3 | Access address type code |
| reqWrite | input | 1 | 1 for a write access |
| chipSel | output | 8 | One-hot chip select, bit n for bank n |
| machSel | output | 2 | Timing engine selected for the access |
| violation | output | 1 | Write to a write-protected bank |
| noMatch | output | 1 | No bank claimed the access |
| parityEn | output | 1 | Parity checking applies to the access |
| parityOdd | output | 1 | Global parity polarity, 1 = odd |
| decodeValid | output | 1 | Outputs carry a decode result this cycle |

## Verification
The hardest case to reach is an overlap. Two valid banks must claim the same address, and the winner must then be withdrawn, so that priority is seen to fall through to a higher bank rather than simply resolving a single hit.

The stimulus first shrinks the reset-time catch-all of bank 0 to a boot window. It then programs banks 1 and 5 over the same region with different machines, and checks which bank wins. Finally it clears bank 1's valid bit and repeats the access. The write-protect case uses the same overlap idea: a protected bank that wins a write must block the access outright, not pass it on to another bank.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  parameter int NUM_BANKS = 8;
  parameter int ADDR_W    = 32;
  parameter int CMP_LSB   = 15;
  parameter int TYPE_W    = 3;
  parameter int MACH_W    = 2;
  parameter int CFG_W     = 32;

  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int CMP_W    = ADDR_W - CMP_LSB;
  localparam int TYPE_LSB = 12;
  localparam int PAR_BIT  = 11;
  localparam int WP_BIT   = 10;
  localparam int MACH_LSB = 8;
  localparam int VAL_BIT  = 0;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_OPT  = 2'd1;
  localparam logic [1:0] SEL_GLOB = 2'd2;

  typedef struct packed {
    logic [CMP_W-1:0]  base;
    logic [TYPE_W-1:0] typeCode;
    logic              parEn;
    logic              wrProt;
    logic [MACH_W-1:0] mach;
    logic              valid;
  } bankBase_t;

  typedef struct packed {
    logic [CMP_W-1:0]  addrMask;
    logic [TYPE_W-1:0] typeMask;
  } bankOpt_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] baseWr;
    logic [NUM_BANKS-1:0] optWr;
    logic                 globWr;
    logic                 capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/bsel_ctrl.sv
module bsel_ctrl
  import bsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [1:0]        cfgSel,
  input  logic              reqValid,
  output ctrlStrobe_t       strobe,
  output logic              decodeValid
);
  logic [NUM_BANKS-1:0] bankDec;

  // one-hot decode of the addressed bank
  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : gDec
      assign bankDec[g] = (cfgBank == BANK_W'(g));
    end
  endgenerate

  always_comb begin
    strobe.baseWr  = (cfgWrEn && cfgSel == SEL_BASE) ? bankDec : '0;
    strobe.optWr   = (cfgWrEn && cfgSel == SEL_OPT)  ? bankDec : '0;
    strobe.globWr  = cfgWrEn && (cfgSel == SEL_GLOB);
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) decodeValid <= 1'b0;
    else       decodeValid <= reqValid;
  end
endmodule

// File: rtl/bsel_datapath.sv
module bsel_datapath
  import bsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TYPE_W-1:0]    reqType,
  input  logic                 reqWrite,
  output logic [NUM_BANKS-1:0] chipSel,
  output logic [MACH_W-1:0]    machSel,
  output logic                 violation,
  output logic                 noMatch,
  output logic                 parityEn,
  output logic                 parityOdd
);
  bankBase_t            baseQ [NUM_BANKS];
  bankOpt_t             optQ  [NUM_BANKS];
  logic                 parOddQ;
  logic [NUM_BANKS-1:0] hit;
  logic [BANK_W-1:0]    winIdx;
  logic                 anyHit;
  logic                 blocked;
  bankBase_t            winBase;
  bankBase_t            cfgBase;
  bankOpt_t             cfgOpt;
  logic                 unusedBits;

  assign unusedBits = ^{cfgData[TYPE_LSB-1:0], reqAddr[CMP_LSB-1:0]};

  // unpack a configuration word into descriptor fields
  always_comb begin
    cfgBase.base     = cfgData[ADDR_W-1:CMP_LSB];
    cfgBase.typeCode = cfgData[TYPE_LSB +: TYPE_W];
    cfgBase.parEn    = cfgData[PAR_BIT];
    cfgBase.wrProt   = cfgData[WP_BIT];
    cfgBase.mach     = cfgData[MACH_LSB +: MACH_W];
    cfgBase.valid    = cfgData[VAL_BIT];
    cfgOpt.addrMask  = cfgData[ADDR_W-1:CMP_LSB];
    cfgOpt.typeMask  = cfgData[TYPE_LSB +: TYPE_W];
  end

  // descriptor storage; bank 0 comes out of reset as a catch-all boot bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        baseQ[i]       <= '0;
        baseQ[i].valid <= (i == 0);
        optQ[i]        <= '0;
      end
      parOddQ <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (strobe.baseWr[i]) baseQ[i] <= cfgBase;
        if (strobe.optWr[i])  optQ[i]  <= cfgOpt;
      end
      if (strobe.globWr) parOddQ <= cfgData[0];
    end
  end

  // per-bank comparators
  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : gCmp
      logic addrOk;
      logic typeOk;
      assign addrOk = ((reqAddr[ADDR_W-1:CMP_LSB] ^ baseQ[g].base) & optQ[g].addrMask) == '0;
      assign typeOk = ((reqType ^ baseQ[g].typeCode) & optQ[g].typeMask) == '0;
      assign hit[g] = baseQ[g].valid && addrOk && typeOk;
    end
  endgenerate

  // lowest-numbered bank wins
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winIdx = BANK_W'(i);
        anyHit = 1'b1;
      end
    end
    winBase = baseQ[winIdx];
    blocked = anyHit && reqWrite && winBase.wrProt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipSel   <= '0;
      machSel   <= '0;
      violation <= 1'b0;
      noMatch   <= 1'b0;
      parityEn  <= 1'b0;
    end else if (strobe.capture && anyHit && !blocked) begin
      chipSel   <= NUM_BANKS'(1) << winIdx;
      machSel   <= winBase.mach;
      violation <= 1'b0;
      noMatch   <= 1'b0;
      parityEn  <= winBase.parEn;
    end else begin
      chipSel   <= '0;
      machSel   <= '0;
      violation <= strobe.capture && blocked;
      noMatch   <= strobe.capture && !anyHit;
      parityEn  <= 1'b0;
    end
  end

  assign parityOdd = parOddQ;
endmodule

// File: rtl/bank_select_unit.sv
module bank_select_unit
  import bsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [BANK_W-1:0]    cfgBank,
  input  logic [1:0]           cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TYPE_W-1:0]    reqType,
  input  logic                 reqWrite,
  output logic [NUM_BANKS-1:0] chipSel,
  output logic [MACH_W-1:0]    machSel,
  output logic                 violation,
  output logic                 noMatch,
  output logic                 parityEn,
  output logic                 parityOdd,
  output logic                 decodeValid
);
  ctrlStrobe_t strobe;

  bsel_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgBank    (cfgBank),
    .cfgSel     (cfgSel),
    .reqValid   (reqValid),
    .strobe     (strobe),
    .decodeValid(decodeValid)
  );

  bsel_datapath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgData  (cfgData),
    .reqAddr  (reqAddr),
    .reqType  (reqType),
    .reqWrite (reqWrite),
    .chipSel  (chipSel),
    .machSel  (machSel),
    .violation(violation),
    .noMatch  (noMatch),
    .parityEn (parityEn),
    .parityOdd(parityOdd)
  );
endmodule

// File: rtl/bsel_chk.sv
module bsel_chk
  import bsel_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [NUM_BANKS-1:0] chipSel,
  input logic [MACH_W-1:0]    machSel,
  input logic                 violation,
  input logic                 noMatch,
  input logic                 parityEn,
  input logic                 decodeValid
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel)); // R4
  AST_VIOL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (chipSel == '0 && !noMatch)); // R5
  AST_VIOL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> $past(reqWrite)); // R5
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> (chipSel == '0 && machSel == '0)); // R6
  AST_PARITY_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    parityEn |-> (chipSel != '0)); // R8
  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decodeValid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!decodeValid && chipSel == '0 && !violation && !noMatch && !parityEn)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid |-> ($countones({|chipSel, violation, noMatch}) == 1)); // R9
endmodule

bind bank_select_unit bsel_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .chipSel    (chipSel),
  .machSel    (machSel),
  .violation  (violation),
  .noMatch    (noMatch),
  .parityEn   (parityEn),
  .decodeValid(decodeValid)
);

// File: tb/tb_bank_select_unit.sv
module tb_bank_select_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgBank = '0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqType = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  chipSel;
  logic [1:0]  machSel;
  logic        violation, noMatch, parityEn, parityOdd, decodeValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_select_unit dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBank(cfgBank), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr), .reqType(reqType),
    .reqWrite(reqWrite), .chipSel(chipSel), .machSel(machSel), .violation(violation),
    .noMatch(noMatch), .parityEn(parityEn), .parityOdd(parityOdd), .decodeValid(decodeValid)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] baseWord(logic [31:0] addr, logic [2:0] tc, bit par,
                                           bit wp, logic [1:0] mach, bit valid);
    return (addr & 32'hFFFF_8000) | {17'b0, tc, par, wp, mach, 7'b0, valid};
  endfunction

  function automatic logic [31:0] optWord(logic [31:0] mask, logic [2:0] tmask);
    return (mask & 32'hFFFF_8000) | {17'b0, tmask, 12'b0};
  endfunction

  task automatic cfgWrite(logic [2:0] bank, logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgBank = bank; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // one access, check the decode cycle and the idle cycle after it
  task automatic access(string tag, logic [31:0] a, logic [2:0] t, bit w,
                        logic [7:0] eCs, logic [1:0] eMach, bit eViol, bit eNm, bit ePar);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqType = t; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    chk(tag, "decodeValid", 32'(decodeValid), 32'd1);
    chk(tag, "chipSel", 32'(chipSel), 32'(eCs));
    chk(tag, "machSel", 32'(machSel), 32'(eMach));
    chk(tag, "violation", 32'(violation), 32'(eViol));
    chk(tag, "noMatch", 32'(noMatch), 32'(eNm));
    chk(tag, "parityEn", 32'(parityEn), 32'(ePar));
    @(negedge clk);
    chk("R9", "idle outputs", 32'({decodeValid, chipSel, violation, noMatch, parityEn}), 32'd0);
  endtask

  task automatic testReset();
    chk("R1", "outputs after reset",
        32'({chipSel, machSel, violation, noMatch, parityEn, parityOdd, decodeValid}), 32'd0);
    access("R1", 32'hDEAD_0000, 3'd5, 1'b1, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0);
    access("R1", 32'h0000_0040, 3'd0, 1'b0, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testAddress();
    cfgWrite(3'd0, 2'd0, baseWord(32'h0000_0000, 3'd0, 0, 0, 2'd0, 1));
    cfgWrite(3'd0, 2'd1, optWord(32'hFF00_0000, 3'd0));
    cfgWrite(3'd1, 2'd0, baseWord(32'h1000_0000, 3'd0, 0, 0, 2'd1, 1));
    cfgWrite(3'd1, 2'd1, optWord(32'hF000_0000, 3'd0));
    access("R2", 32'h1234_5678, 3'd0, 1'b0, 8'h02, 2'd1, 0, 0, 0);
    access("R7", 32'h1FFF_FFFC, 3'd3, 1'b1, 8'h02, 2'd1, 0, 0, 0);
    access("R2", 32'h00FF_0000, 3'd0, 1'b0, 8'h01, 2'd0, 0, 0, 0);
    access("R6", 32'h2000_0000, 3'd0, 1'b0, 8'h00, 2'd0, 0, 1, 0);
    // bank 6 programmed but invalid: must not match
    cfgWrite(3'd6, 2'd0, baseWord(32'h2000_0000, 3'd0, 0, 0, 2'd2, 0));
    access("R2", 32'h2000_0000, 3'd0, 1'b0, 8'h00, 2'd0, 0, 1, 0);
    // select 3 is ignored: bank 1 unchanged
    cfgWrite(3'd1, 2'd3, 32'h0000_0000);
    access("R10", 32'h1000_0000, 3'd0, 1'b0, 8'h02, 2'd1, 0, 0, 0);
  endtask

  task automatic testType();
    cfgWrite(3'd2, 2'd0, baseWord(32'h3000_0000, 3'b100, 1, 0, 2'd2, 1));
    cfgWrite(3'd2, 2'd1, optWord(32'hF000_0000, 3'b110));
    access("R3", 32'h3000_1000, 3'b101, 1'b0, 8'h04, 2'd2, 0, 0, 1);
    access("R3", 32'h3000_1000, 3'b100, 1'b1, 8'h04, 2'd2, 0, 0, 1);
    access("R3", 32'h3000_1000, 3'b001, 1'b0, 8'h00, 2'd0, 0, 1, 0);
    access("R3", 32'h3000_1000, 3'b110, 1'b0, 8'h00, 2'd0, 0, 1, 0);
  endtask

  task automatic testPriority();
    cfgWrite(3'd5, 2'd0, baseWord(32'h1000_0000, 3'd0, 0, 0, 2'd2, 1));
    cfgWrite(3'd5, 2'd1, optWord(32'hF000_0000, 3'd0));
    access("R4", 32'h1000_8000, 3'd0, 1'b0, 8'h02, 2'd1, 0, 0, 0);
    cfgWrite(3'd1, 2'd0, baseWord(32'h1000_0000, 3'd0, 0, 0, 2'd1, 0));
    access("R4", 32'h1000_8000, 3'd0, 1'b0, 8'h20, 2'd2, 0, 0, 0);
  endtask

  task automatic testProtect();
    cfgWrite(3'd3, 2'd0, baseWord(32'h4000_0000, 3'd0, 1, 1, 2'd1, 1));
    cfgWrite(3'd3, 2'd1, optWord(32'hF000_0000, 3'd0));
    cfgWrite(3'd7, 2'd0, baseWord(32'h4000_0000, 3'd0, 0, 0, 2'd2, 1));
    cfgWrite(3'd7, 2'd1, optWord(32'hF000_0000, 3'd0));
    access("R5", 32'h4000_0100, 3'd0, 1'b0, 8'h08, 2'd1, 0, 0, 1);
    access("R5", 32'h4000_0100, 3'd0, 1'b1, 8'h00, 2'd0, 1, 0, 0);
  endtask

  task automatic testParity();
    chk("R8", "parityOdd default", 32'(parityOdd), 32'd0);
    cfgWrite(3'd0, 2'd2, 32'h0000_0001);
    chk("R8", "parityOdd set", 32'(parityOdd), 32'd1);
    access("R8", 32'h3000_0000, 3'b100, 1'b0, 8'h04, 2'd2, 0, 0, 1);
    access("R8", 32'h0000_0000, 3'd0, 1'b0, 8'h01, 2'd0, 0, 0, 0);
    cfgWrite(3'd4, 2'd2, 32'h0000_0000);
    chk("R10", "parityOdd cleared", 32'(parityOdd), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddress();
    testType();
    testPriority();
    testProtect();
    testParity();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule